// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive datapath of an Ethernet MAC and decides whether each incoming frame should be kept or thrown away. The datapath presents the first six bytes of the frame, the destination address, one byte per qualified cycle after a frame-start marker. While the bytes stream in, the filter keeps the address and runs a CRC-32 over it. When the sixth byte has arrived it issues a registered verdict: an accept flag and a code that says which rule matched.

Four rules are configured by static inputs. Promiscuous mode takes every frame. The all-ones broadcast address is taken only when broadcast reception is enabled. Group (multicast) addresses go through a 64-bin hash table held in two 32-bit words. Individual (unicast) addresses must equal the programmed station address exactly. Software accepts every multicast group by filling both hash words with ones.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, verdict_valid and verdict_accept are 0 and verdict_reason is 0 (drop).
- R2: Bytes are taken in wire order, and the first byte is address byte 0. verdict_valid stays low on the clock edge that takes the sixth byte and rises on the next edge.
- R3: For a group address (bit 0 of byte 0 set, not all ones), take the big-endian CRC-32 of the six bytes: initial value all ones, polynomial 0x04C11DB7, each byte fed LSB first, no final inversion. Bits 31:26 form the bin number. Bin bit 5 picks cfg_hash_hi (1) or cfg_hash_lo (0), and bits 4:0 pick the bit within that word. With cfg_mcast_en set, the frame is accepted with reason 2 exactly when that table bit is 1.
- R4: With both hash words all ones, every group address is accepted when cfg_mcast_en is 1. With cfg_mcast_en at 0, no group address is accepted, whatever the table holds.
- R5: The all-ones address is broadcast and never goes through the hash. It is accepted with reason 3 exactly when cfg_bcast_en is 1.
- R6: An individual address is accepted with reason 1 only when cfg_ucast_en is 1 and it equals the station address on all 48 bits. cfg_station_hi holds bytes 0..2, with byte 0 in bits 23:16. cfg_station_lo holds bytes 3..5, with byte 3 in bits 23:16.
- R7: cfg_promisc_en accepts every frame with reason 4, and it overrides all other rules.
- R8: A verdict holds its value until the next frame_start. Bytes after the sixth do not change it. A frame_start makes verdict_valid, verdict_accept and verdict_reason zero on the next edge.
- R9: A frame_start with byte_valid in the same cycle counts that byte as address byte 0. A frame_start without byte_valid waits for byte 0 in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | New frame begins; clears the previous verdict |
| byte_valid | input | 1 | byte_data carries a frame byte |
| byte_data | input | 8 | Frame byte, destination bytes first |
| cfg_station_hi | input | 24 | Station address bytes 0..2 |
| cfg_station_lo | input | 24 | Station address bytes 3..5 |
| cfg_hash_lo | input | 32 | Hash bins 0..31 |
| cfg_hash_hi | input | 32 | Hash bins 32..63 |
| cfg_ucast_en | input | 1 | Enable exact station-address match |
| cfg_mcast_en | input | 1 | Enable hash-filtered group addresses |
| cfg_bcast_en | input | 1 | Enable broadcast reception |
| cfg_promisc_en | input | 1 | Accept every frame |
| verdict_valid | output | 1 | Verdict for the current frame is ready |
| verdict_accept | output | 1 | Frame is kept |
| verdict_reason | output | 3 | 0 drop, 1 unicast, 2 multicast, 3 broadcast, 4 promiscuous |

## Verification
On every cycle, assertions check that a verdict holds steady until frame_start, that frame_start clears it, and that accept is never high without valid. They also check that a reason code only appears when its enable was set and that promiscuous mode always wins. They cannot show that the CRC bin number and the table bit are the right ones, that the full 48-bit station compare works, or that the latency is exact. Only the bench scenarios can show those. The bench sweeps every enable combination against each address class, flips each station-address bit in turn, and runs hundreds of group addresses against complementary hash tables.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    RSN_DROP    = 3'd0,
    RSN_UCAST   = 3'd1,
    RSN_MCAST   = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_PROMISC = 3'd4
  } rsn_e;
endpackage

// File: rtl/rxf_crc_byte.sv
// One byte step of a left-shifting CRC, data fed LSB first.
module rxf_crc_byte #(
  parameter int              DATA_W = 8,
  parameter int              CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY  = rxf_pkg::CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = 0; i < DATA_W; i++) begin
      fb = c[CRC_W-1] ^ data_in[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
    end
    crc_out = c;
  end
endmodule

// File: rtl/rxf_capture.sv
// Collects the destination bytes and accumulates the CRC as they arrive.
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  byte_valid,
  input  logic [BYTE_W-1:0]     byte_data,
  output logic [ADDR_W-1:0]     addr,
  output logic [HASH_IDX_W-1:0] hash_idx,
  output logic                  done
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, eff_cnt;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_base, crc_upd;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_base;
  logic              done_q, done_d;
  logic              take, upd_en;

  rxf_crc_byte #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .crc_in  (crc_base),
    .data_in (byte_data),
    .crc_out (crc_upd)
  );

  always_comb begin
    eff_cnt   = frame_start ? '0 : cnt_q;
    crc_base  = frame_start ? CRC_SEED : crc_q;
    addr_base = frame_start ? '0 : addr_q;
    take      = byte_valid && (eff_cnt < CNT_W'(ADDR_BYTES));
    upd_en    = frame_start || take;
    cnt_d     = take ? eff_cnt + CNT_W'(1) : eff_cnt;
    crc_d     = take ? crc_upd : crc_base;
    addr_d    = take ? {addr_base[ADDR_W-BYTE_W-1:0], byte_data} : addr_base;
    done_d    = take && (eff_cnt == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (upd_en) begin
        cnt_q  <= cnt_d;
        crc_q  <= crc_d;
        addr_q <= addr_d;
      end
      done_q <= done_d;
    end
  end

  assign addr     = addr_q;
  assign hash_idx = crc_q[CRC_W-1 -: HASH_IDX_W];
  assign done     = done_q;

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  a_r2_done_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(byte_valid));
endmodule

// File: rtl/rxf_decide.sv
// Rule evaluation and the registered verdict.
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int HASH_IDX_W = 6,
  localparam int HALF_W    = ADDR_W / 2,
  localparam int TBL_W     = (1 << HASH_IDX_W) / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  done,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [HASH_IDX_W-1:0] hash_idx,
  input  logic [HALF_W-1:0]     cfg_station_hi,
  input  logic [HALF_W-1:0]     cfg_station_lo,
  input  logic [TBL_W-1:0]      cfg_hash_lo,
  input  logic [TBL_W-1:0]      cfg_hash_hi,
  input  logic                  cfg_ucast_en,
  input  logic                  cfg_mcast_en,
  input  logic                  cfg_bcast_en,
  input  logic                  cfg_promisc_en,
  output logic                  verdict_valid,
  output logic                  verdict_accept,
  output logic [2:0]            verdict_reason
);
  logic                  is_bcast, is_group, uc_hit, tbl_hit;
  logic [HASH_IDX_W-2:0] bin;
  rsn_e                  rsn_eval;
  logic                  valid_q, valid_n, acc_q, acc_n;
  rsn_e                  rsn_q, rsn_n;

  always_comb begin
    is_bcast = &addr;
    is_group = addr[ADDR_W-BYTE_W] & ~is_bcast;
    uc_hit   = (addr == {cfg_station_hi, cfg_station_lo});
    bin      = hash_idx[HASH_IDX_W-2:0];
    tbl_hit  = hash_idx[HASH_IDX_W-1] ? cfg_hash_hi[bin] : cfg_hash_lo[bin];
    if (cfg_promisc_en)
      rsn_eval = RSN_PROMISC;
    else if (is_bcast)
      rsn_eval = cfg_bcast_en ? RSN_BCAST : RSN_DROP;
    else if (is_group)
      rsn_eval = (cfg_mcast_en && tbl_hit) ? RSN_MCAST : RSN_DROP;
    else
      rsn_eval = (cfg_ucast_en && uc_hit) ? RSN_UCAST : RSN_DROP;
  end

  always_comb begin
    valid_n = valid_q;
    acc_n   = acc_q;
    rsn_n   = rsn_q;
    if (frame_start) begin
      valid_n = 1'b0;
      acc_n   = 1'b0;
      rsn_n   = RSN_DROP;
    end else if (done) begin
      valid_n = 1'b1;
      acc_n   = (rsn_eval != RSN_DROP);
      rsn_n   = rsn_eval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      rsn_q   <= RSN_DROP;
    end else begin
      valid_q <= valid_n;
      acc_q   <= acc_n;
      rsn_q   <= rsn_n;
    end
  end

  assign verdict_valid  = valid_q;
  assign verdict_accept = acc_q;
  assign verdict_reason = rsn_q;

  a_r8_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !frame_start) |=> (valid_q && $stable(acc_q) && $stable(rsn_q)));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !valid_q);

  a_r1_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> valid_q);

  a_r7_promisc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_q) && $past(cfg_promisc_en)) |-> (acc_q && rsn_q == RSN_PROMISC));

  a_r5_bcast_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_q) && rsn_q == RSN_BCAST) |-> $past(cfg_bcast_en));

  a_r4_mcast_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_q) && rsn_q == RSN_MCAST) |-> $past(cfg_mcast_en));

  a_r6_ucast_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_q) && rsn_q == RSN_UCAST) |-> $past(cfg_ucast_en));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int HALF_W    = ADDR_W / 2,
  localparam int TBL_W     = (1 << HASH_IDX_W) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [HALF_W-1:0] cfg_station_hi,
  input  logic [HALF_W-1:0] cfg_station_lo,
  input  logic [TBL_W-1:0]  cfg_hash_lo,
  input  logic [TBL_W-1:0]  cfg_hash_hi,
  input  logic              cfg_ucast_en,
  input  logic              cfg_mcast_en,
  input  logic              cfg_bcast_en,
  input  logic              cfg_promisc_en,
  output logic              verdict_valid,
  output logic              verdict_accept,
  output logic [2:0]        verdict_reason
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic [ADDR_W-1:0]     cap_addr;
  logic [HASH_IDX_W-1:0] cap_idx;
  logic                  cap_done;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rxf_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_IDX_W(HASH_IDX_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (frame_start),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .addr        (cap_addr),
    .hash_idx    (cap_idx),
    .done        (cap_done)
  );

  rxf_decide #(.ADDR_W(ADDR_W), .HASH_IDX_W(HASH_IDX_W)) u_dec (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .frame_start    (frame_start),
    .done           (cap_done),
    .addr           (cap_addr),
    .hash_idx       (cap_idx),
    .cfg_station_hi (cfg_station_hi),
    .cfg_station_lo (cfg_station_lo),
    .cfg_hash_lo    (cfg_hash_lo),
    .cfg_hash_hi    (cfg_hash_hi),
    .cfg_ucast_en   (cfg_ucast_en),
    .cfg_mcast_en   (cfg_mcast_en),
    .cfg_bcast_en   (cfg_bcast_en),
    .cfg_promisc_en (cfg_promisc_en),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .verdict_reason (verdict_reason)
  );
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  logic        clk;
  logic        rst_n;
  logic        frame_start, byte_valid;
  logic [7:0]  byte_data;
  logic [23:0] cfg_station_hi, cfg_station_lo;
  logic [31:0] cfg_hash_lo, cfg_hash_hi;
  logic        cfg_ucast_en, cfg_mcast_en, cfg_bcast_en, cfg_promisc_en;
  logic        verdict_valid, verdict_accept;
  logic [2:0]  verdict_reason;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [47:0] STATION = 48'h1234_569A_BCDE;
  localparam logic [47:0] OTHER_UC = 48'h0246_8ACE_1357;
  localparam logic [47:0] GROUP_A = 48'h0100_5E7F_0A01;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .cfg_station_hi(cfg_station_hi), .cfg_station_lo(cfg_station_lo),
    .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi), .cfg_ucast_en(cfg_ucast_en),
    .cfg_mcast_en(cfg_mcast_en), .cfg_bcast_en(cfg_bcast_en), .cfg_promisc_en(cfg_promisc_en),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept), .verdict_reason(verdict_reason)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bit-serial CRC over the whole address, byte 0 first, each byte LSB first.
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int j = 0; j < 48; j++) begin
      logic b = a[40 - 8 * (j / 8) + (j % 8)];
      logic top = c[31] ^ b;
      c = c << 1;
      if (top) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [3:0] ref_verdict(input logic [47:0] a);
    logic [63:0] tbl = {cfg_hash_hi, cfg_hash_lo};
    logic [2:0]  r;
    if (cfg_promisc_en) r = 3'd4;
    else if (a == BCAST) r = cfg_bcast_en ? 3'd3 : 3'd0;
    else if (a[40]) r = (cfg_mcast_en && tbl[ref_bin(a)]) ? 3'd2 : 3'd0;
    else r = (cfg_ucast_en && a == {cfg_station_hi, cfg_station_lo}) ? 3'd1 : 3'd0;
    return {r != 3'd0, r};
  endfunction

  // Called just after a falling edge; returns just after a falling edge.
  task automatic send_frame(input logic [47:0] a, input bit sep, input int extra, input string tag);
    logic [3:0] exp = ref_verdict(a);
    if (sep) begin
      frame_start = 1'b1; byte_valid = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 6; k++) begin
      frame_start = (k == 0) && !sep;
      byte_valid  = 1'b1;
      byte_data   = a[47 - 8 * k -: 8];
      @(negedge clk);
    end
    frame_start = 1'b0;
    byte_valid  = (extra > 0);
    byte_data   = 8'hA5;
    chk("R2 valid low on last-byte edge", verdict_valid, 0);
    @(negedge clk);
    chk("R2 valid one edge later", verdict_valid, 1);
    chk({tag, " accept"}, verdict_accept, exp[3]);
    chk({tag, " reason"}, verdict_reason, exp[2:0]);
    for (int e = 1; e < extra; e++) begin
      byte_data = 8'(e * 37);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    if (extra > 0) begin
      chk("R8 held valid", verdict_valid, 1);
      chk("R8 held accept", verdict_accept, exp[3]);
      chk("R8 held reason", verdict_reason, exp[2:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; byte_valid = 1'b0; byte_data = 8'h00;
    cfg_station_hi = STATION[47:24]; cfg_station_lo = STATION[23:0];
    cfg_hash_lo = 32'h0; cfg_hash_hi = 32'h0;
    cfg_ucast_en = 1'b0; cfg_mcast_en = 1'b0; cfg_bcast_en = 1'b0; cfg_promisc_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset valid", verdict_valid, 0);
    chk("R1 reset accept", verdict_accept, 0);
    chk("R1 reset reason", verdict_reason, 0);

    // Every enable combination against every address class.
    cfg_hash_lo = 32'hA5A5_5A5A; cfg_hash_hi = 32'h0F0F_F0F0;
    for (int m = 0; m < 16; m++) begin
      {cfg_promisc_en, cfg_bcast_en, cfg_mcast_en, cfg_ucast_en} = 4'(m);
      send_frame(STATION,  0, 0, m[3] ? "R7" : "R6");
      send_frame(OTHER_UC, 0, 0, m[3] ? "R7" : "R6");
      send_frame(GROUP_A,  0, 0, m[3] ? "R7" : "R3");
      send_frame(BCAST,    0, 0, m[3] ? "R7" : "R5");
    end

    // Single-bit near misses of the station address.
    {cfg_promisc_en, cfg_bcast_en, cfg_mcast_en, cfg_ucast_en} = 4'b0001;
    for (int b = 0; b < 48; b++) send_frame(STATION ^ (48'd1 << b), 0, 0, "R6");

    // Group addresses against a table and its complement.
    {cfg_promisc_en, cfg_bcast_en, cfg_mcast_en, cfg_ucast_en} = 4'b0010;
    for (int p = 0; p < 2; p++) begin
      cfg_hash_lo = p[0] ? ~32'h3C5A_96E1 : 32'h3C5A_96E1;
      cfg_hash_hi = p[0] ? ~32'hC3A5_691E : 32'hC3A5_691E;
      for (int i = 0; i < 128; i++)
        send_frame({8'h01, 8'h00, 8'h5E, 8'(i * 3), 8'(i ^ 8'h55), 8'(i)}, 0, 0, "R3");
    end

    // All-ones table.
    cfg_hash_lo = '1; cfg_hash_hi = '1;
    for (int i = 0; i < 32; i++)
      send_frame({8'(8'h03 + 8'(i * 4)), 8'(i), 8'h77, 8'h10, 8'(i * 9), 8'hC4}, 0, 0, "R4");
    send_frame(BCAST, 0, 0, "R5");
    cfg_mcast_en = 1'b0;
    send_frame(GROUP_A, 0, 0, "R4");

    // Hold across trailing bytes, then clear by frame_start.
    cfg_ucast_en = 1'b1;
    send_frame(STATION, 0, 5, "R6");
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R8 start clears valid", verdict_valid, 0);
    chk("R8 start clears accept", verdict_accept, 0);
    chk("R8 start clears reason", verdict_reason, 0);

    // Start marker in a cycle of its own.
    send_frame(STATION, 1, 0, "R9");
    send_frame(OTHER_UC, 1, 3, "R9");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule